// File: doc/BRIEF.md
# Peripheral Reset Controller

This block owns the control and status registers of a host port and two general-purpose I/O ports, and applies four distinct reset causes to them bit by bit. The causes are a hardware reset strobe, a software reset strobe, a stop reset strobe, and per-peripheral individual resets. Each register field has a fixed reset value. A fixed set of causes forces the field to that value; every other cause leaves it alone.

An individual reset is raised whenever a peripheral has given up all of its pins to general-purpose I/O. The host port is in individual reset while its single port B enable bit is clear. The asynchronous serial interface is in individual reset while port C control bits 2..0 are all zero. The synchronous serial interface is in individual reset while port C control bits 8..3 are all zero. The two serial individual resets are driven out to the serial blocks. The host individual reset is also applied inside the controller to the host registers.

Registers are loaded through a single write port with a select code. A write is dropped in any cycle in which a cause that affects the target register is active.

Top module: `prst_ctrl`

## Requirements
- R1: While rst_ni is low, the registers take these values: bus_ctl_o = 16'hFFFF; all port control, direction and data registers = 0; host_ctl_o = 0; host_sts_o = 6'b000010; host_ictl_o = 0; host_cmd_o = 6'h12; host_isr_o = 4'b0110; host_ivec_o = 8'h0F. All three individual-reset outputs are then high.
- R2: The individual-reset outputs follow the register contents without delay. host_irst_o is high when pb_ctl_o is 0. sci_irst_o is high when pc_ctl_o[2:0] is all zero. ssi_irst_o is high when pc_ctl_o[8:3] is all zero.
- R3: hw_rst_i high at a clock edge sets bus_ctl_o to 16'hFFFF. sw_rst_i and stop_rst_i do not change bus_ctl_o.
- R4: pb_ctl_o, pb_dir_o, pc_ctl_o and pc_dir_o clear on hw_rst_i or sw_rst_i. They hold on stop_rst_i.
- R5: pb_dat_o and pc_dat_o change only through writes. No reset strobe or individual reset alters them.
- R6: host_ctl_o clears on hw_rst_i or sw_rst_i. It holds on stop_rst_i and during the host individual reset.
- R7: host_sts_o has the layout {dma[5], hf1[4], hf0[3], hcp[2], tx_empty[1], rx_full[0]}. It becomes 6'b000010 on hw_rst_i, sw_rst_i or stop_rst_i, and in every cycle host_irst_o is high.
- R8: On any of those four causes, host_cmd_o ({cmd_pend[5], vec[4:0]}) becomes 6'h12 and host_ictl_o ({init, mode[1:0], tx_req_en, rx_req_en}) becomes 0. host_isr_o ({req[3], tx_rdy[2], tx_empty[1], rx_full[0]}) becomes 4'b0110.
- R9: host_ivec_o becomes 8'h0F on hw_rst_i or sw_rst_i. It holds on stop_rst_i and during the host individual reset.
- R10: With wr_en_i high, wr_sel_i selects the register: 0 bus_ctl, 1 pb_ctl, 2 pb_dir, 3 pb_dat, 4 pc_ctl, 5 pc_dir, 6 pc_dat, 7 host_ctl, 8 host_sts, 9 host_ictl, 10 host_cmd, 11 host_isr, 12 host_ivec; codes 13 to 15 write nothing. The low bits of wr_data_i load at the next edge. The write is dropped if a cause affecting that register is active in the same cycle.
- R11: When causes coincide, each register takes the result of the highest-ranked cause that affects it. The ranking is hardware, software, stop, individual. For example, software and stop together clear the port direction registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| hw_rst_i | input | 1 | Hardware reset cause, level |
| sw_rst_i | input | 1 | Software reset cause, level |
| stop_rst_i | input | 1 | Stop reset cause, level |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 4 | Register select code |
| wr_data_i | input | 16 | Write data |
| bus_ctl_o | output | 16 | External bus wait-state control |
| pb_ctl_o | output | 1 | Port B control (host pin enable) |
| pb_dir_o | output | 15 | Port B direction |
| pb_dat_o | output | 15 | Port B data |
| pc_ctl_o | output | 9 | Port C control |
| pc_dir_o | output | 9 | Port C direction |
| pc_dat_o | output | 9 | Port C data |
| host_ctl_o | output | 5 | Host control enables, core side |
| host_sts_o | output | 6 | Host status, core side |
| host_ictl_o | output | 5 | Host interface control, host side |
| host_cmd_o | output | 6 | Host command vector, host side |
| host_isr_o | output | 4 | Host status, host side |
| host_ivec_o | output | 8 | Host interrupt vector, host side |
| host_irst_o | output | 1 | Host individual reset |
| sci_irst_o | output | 1 | Asynchronous serial individual reset |
| ssi_irst_o | output | 1 | Synchronous serial individual reset |

## Verification
Two kinds of event can land on the same edge: a register write and a reset cause, or two or more reset causes. The bench provokes both on purpose. It applies a software strobe together with a bus-control write, which must be accepted. It applies a stop strobe together with a host-status write, which must be dropped. It applies software and stop together, and then all three strobes together, while writing a data register. A random phase then overlaps strobes, writes and pin-configuration changes freely. A behavioural model, which ORs the causes that affect each field, judges every cycle.

// File: rtl/prst_pkg.sv
package prst_pkg;
  typedef enum logic [3:0] {
    SEL_BUS    = 4'd0,
    SEL_PB_CTL = 4'd1,
    SEL_PB_DIR = 4'd2,
    SEL_PB_DAT = 4'd3,
    SEL_PC_CTL = 4'd4,
    SEL_PC_DIR = 4'd5,
    SEL_PC_DAT = 4'd6,
    SEL_H_CTL  = 4'd7,
    SEL_H_STS  = 4'd8,
    SEL_H_ICTL = 4'd9,
    SEL_H_CMD  = 4'd10,
    SEL_H_ISR  = 4'd11,
    SEL_H_IVEC = 4'd12
  } reg_sel_e;

  localparam int N_REG = 13;
  localparam int SEL_W = 4;

  // cause mask bit order = rank: hw, sw, stop, individual
  typedef logic [3:0] cause_mask_t;
  localparam cause_mask_t AFF_NONE  = 4'b0000;
  localparam cause_mask_t AFF_HW    = 4'b0001;
  localparam cause_mask_t AFF_HW_SW = 4'b0011;
  localparam cause_mask_t AFF_ALL   = 4'b1111;
endpackage

// File: rtl/prst_wr_dec.sv
module prst_wr_dec #(
  parameter int N_REG = 13,
  parameter int SEL_W = 4
) (
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  output logic [N_REG-1:0] we_o
);
  for (genvar i = 0; i < N_REG; i++) begin : g_we
    assign we_o[i] = wr_en_i && (wr_sel_i == SEL_W'(i));
  end
endmodule

// File: rtl/prst_indiv_dec.sv
module prst_indiv_dec #(
  parameter int PC_W     = 9,
  parameter int SCI_BITS = 3
) (
  input  logic            pb_ctl_i,
  input  logic [PC_W-1:0] pc_ctl_i,
  output logic            host_irst_o,
  output logic            sci_irst_o,
  output logic            ssi_irst_o
);
  localparam int SSI_LO = SCI_BITS;
  localparam int SSI_HI = PC_W - 1;

  assign host_irst_o = ~pb_ctl_i;
  assign sci_irst_o  = ~|pc_ctl_i[SCI_BITS-1:0];
  assign ssi_irst_o  = ~|pc_ctl_i[SSI_HI:SSI_LO];
endmodule

// File: rtl/prst_field.sv
module prst_field #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [3:0]  AFF     = 4'b0000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [3:0]   act_i,
  input  logic         we_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] q_o
);
  logic [3:0] hit_vec;
  logic       hit;

  // every affecting cause shares one reset value, so rank resolves to "any"
  assign hit_vec = act_i & AFF;
  assign hit     = |hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (hit)  q_o <= RST_VAL;
    else if (we_i) q_o <= wd_i;
  end
endmodule

// File: rtl/prst_ctrl.sv
module prst_ctrl
  import prst_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PB_W     = 15,
  parameter int PC_W     = 9,
  parameter int SCI_BITS = 3,
  parameter int HV_W     = 5,
  parameter int IVEC_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_rst_i,
  input  logic              sw_rst_i,
  input  logic              stop_rst_i,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] bus_ctl_o,
  output logic              pb_ctl_o,
  output logic [PB_W-1:0]   pb_dir_o,
  output logic [PB_W-1:0]   pb_dat_o,
  output logic [PC_W-1:0]   pc_ctl_o,
  output logic [PC_W-1:0]   pc_dir_o,
  output logic [PC_W-1:0]   pc_dat_o,
  output logic [4:0]        host_ctl_o,
  output logic [5:0]        host_sts_o,
  output logic [4:0]        host_ictl_o,
  output logic [HV_W:0]     host_cmd_o,
  output logic [3:0]        host_isr_o,
  output logic [IVEC_W-1:0] host_ivec_o,
  output logic              host_irst_o,
  output logic              sci_irst_o,
  output logic              ssi_irst_o
);
  localparam int HCTL_W  = 5;
  localparam int HSTS_W  = 6;
  localparam int HICTL_W = 5;
  localparam int HCMD_W  = HV_W + 1;
  localparam int HISR_W  = 4;

  localparam logic [HSTS_W-1:0] HSTS_RST = HSTS_W'(6'b000010);
  localparam logic [HCMD_W-1:0] HCMD_RST = HCMD_W'(6'h12);
  localparam logic [HISR_W-1:0] HISR_RST = HISR_W'(4'b0110);
  localparam logic [IVEC_W-1:0] IVEC_RST = IVEC_W'(8'h0F);

  logic [N_REG-1:0] we;
  logic [3:0]       act_port, act_host;

  prst_wr_dec #(.N_REG(N_REG), .SEL_W(SEL_W)) u_wr_dec (
    .wr_en_i (wr_en_i),
    .wr_sel_i(wr_sel_i),
    .we_o    (we)
  );

  prst_indiv_dec #(.PC_W(PC_W), .SCI_BITS(SCI_BITS)) u_indiv (
    .pb_ctl_i   (pb_ctl_o),
    .pc_ctl_i   (pc_ctl_o),
    .host_irst_o(host_irst_o),
    .sci_irst_o (sci_irst_o),
    .ssi_irst_o (ssi_irst_o)
  );

  assign act_port = {1'b0,        stop_rst_i, sw_rst_i, hw_rst_i};
  assign act_host = {host_irst_o, stop_rst_i, sw_rst_i, hw_rst_i};

  // port side
  prst_field #(.W(DATA_W), .RST_VAL('1), .AFF(AFF_HW)) u_bus (
    .clk_i, .rst_ni, .act_i(act_port), .we_i(we[SEL_BUS]),
    .wd_i(wr_data_i), .q_o(bus_ctl_o));

  prst_field #(.W(1), .RST_VAL(1'b0), .AFF(AFF_HW_SW)) u_pb_ctl (
    .clk_i, .rst_ni, .act_i(act_port), .we_i(we[SEL_PB_CTL]),
    .wd_i(wr_data_i[0]), .q_o(pb_ctl_o));

  prst_field #(.W(PB_W), .RST_VAL('0), .AFF(AFF_HW_SW)) u_pb_dir (
    .clk_i, .rst_ni, .act_i(act_port), .we_i(we[SEL_PB_DIR]),
    .wd_i(wr_data_i[PB_W-1:0]), .q_o(pb_dir_o));

  prst_field #(.W(PB_W), .RST_VAL('0), .AFF(AFF_NONE)) u_pb_dat (
    .clk_i, .rst_ni, .act_i(act_port), .we_i(we[SEL_PB_DAT]),
    .wd_i(wr_data_i[PB_W-1:0]), .q_o(pb_dat_o));

  prst_field #(.W(PC_W), .RST_VAL('0), .AFF(AFF_HW_SW)) u_pc_ctl (
    .clk_i, .rst_ni, .act_i(act_port), .we_i(we[SEL_PC_CTL]),
    .wd_i(wr_data_i[PC_W-1:0]), .q_o(pc_ctl_o));

  prst_field #(.W(PC_W), .RST_VAL('0), .AFF(AFF_HW_SW)) u_pc_dir (
    .clk_i, .rst_ni, .act_i(act_port), .we_i(we[SEL_PC_DIR]),
    .wd_i(wr_data_i[PC_W-1:0]), .q_o(pc_dir_o));

  prst_field #(.W(PC_W), .RST_VAL('0), .AFF(AFF_NONE)) u_pc_dat (
    .clk_i, .rst_ni, .act_i(act_port), .we_i(we[SEL_PC_DAT]),
    .wd_i(wr_data_i[PC_W-1:0]), .q_o(pc_dat_o));

  // host side
  prst_field #(.W(HCTL_W), .RST_VAL('0), .AFF(AFF_HW_SW)) u_h_ctl (
    .clk_i, .rst_ni, .act_i(act_host), .we_i(we[SEL_H_CTL]),
    .wd_i(wr_data_i[HCTL_W-1:0]), .q_o(host_ctl_o));

  prst_field #(.W(HSTS_W), .RST_VAL(HSTS_RST), .AFF(AFF_ALL)) u_h_sts (
    .clk_i, .rst_ni, .act_i(act_host), .we_i(we[SEL_H_STS]),
    .wd_i(wr_data_i[HSTS_W-1:0]), .q_o(host_sts_o));

  prst_field #(.W(HICTL_W), .RST_VAL('0), .AFF(AFF_ALL)) u_h_ictl (
    .clk_i, .rst_ni, .act_i(act_host), .we_i(we[SEL_H_ICTL]),
    .wd_i(wr_data_i[HICTL_W-1:0]), .q_o(host_ictl_o));

  prst_field #(.W(HCMD_W), .RST_VAL(HCMD_RST), .AFF(AFF_ALL)) u_h_cmd (
    .clk_i, .rst_ni, .act_i(act_host), .we_i(we[SEL_H_CMD]),
    .wd_i(wr_data_i[HCMD_W-1:0]), .q_o(host_cmd_o));

  prst_field #(.W(HISR_W), .RST_VAL(HISR_RST), .AFF(AFF_ALL)) u_h_isr (
    .clk_i, .rst_ni, .act_i(act_host), .we_i(we[SEL_H_ISR]),
    .wd_i(wr_data_i[HISR_W-1:0]), .q_o(host_isr_o));

  prst_field #(.W(IVEC_W), .RST_VAL(IVEC_RST), .AFF(AFF_HW_SW)) u_h_ivec (
    .clk_i, .rst_ni, .act_i(act_host), .we_i(we[SEL_H_IVEC]),
    .wd_i(wr_data_i[IVEC_W-1:0]), .q_o(host_ivec_o));
endmodule

// File: rtl/prst_ctrl_chk.sv
module prst_ctrl_chk
  import prst_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PB_W   = 15,
  parameter int PC_W   = 9,
  parameter int HV_W   = 5,
  parameter int IVEC_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hw_rst_i,
  input logic              sw_rst_i,
  input logic              stop_rst_i,
  input logic              wr_en_i,
  input logic [3:0]        wr_sel_i,
  input logic [DATA_W-1:0] bus_ctl_o,
  input logic              pb_ctl_o,
  input logic [PB_W-1:0]   pb_dir_o,
  input logic [PB_W-1:0]   pb_dat_o,
  input logic [PC_W-1:0]   pc_ctl_o,
  input logic [PC_W-1:0]   pc_dir_o,
  input logic [5:0]        host_sts_o,
  input logic [4:0]        host_ictl_o,
  input logic [HV_W:0]     host_cmd_o,
  input logic [3:0]        host_isr_o,
  input logic [IVEC_W-1:0] host_ivec_o,
  input logic              host_irst_o,
  input logic              sci_irst_o,
  input logic              ssi_irst_o
);
  // R3
  bus_hw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_rst_i |=> bus_ctl_o == '1);

  // R3
  bus_soft_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_rst_i && (sw_rst_i || stop_rst_i) && !(wr_en_i && wr_sel_i == SEL_BUS))
    |=> $stable(bus_ctl_o));

  // R4
  port_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_rst_i || sw_rst_i) |=>
      (pb_ctl_o == 1'b0 && pb_dir_o == '0 && pc_ctl_o == '0 && pc_dir_o == '0));

  // R5
  pb_dat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_sel_i == SEL_PB_DAT) |=> $stable(pb_dat_o));

  // R7
  host_sts_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_rst_i || sw_rst_i || stop_rst_i || host_irst_o) |=> host_sts_o == 6'b000010);

  // R8
  host_side_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_rst_i || sw_rst_i || stop_rst_i || host_irst_o) |=>
      (host_cmd_o == 6'h12 && host_isr_o == 4'b0110 && host_ictl_o == 5'd0));

  // R9
  ivec_stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_rst_i && !hw_rst_i && !sw_rst_i && !(wr_en_i && wr_sel_i == SEL_H_IVEC))
    |=> $stable(host_ivec_o));

  // R2
  irst_after_hw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_rst_i |=> (host_irst_o && sci_irst_o && ssi_irst_o));
endmodule

bind prst_ctrl prst_ctrl_chk #(
  .DATA_W(DATA_W), .PB_W(PB_W), .PC_W(PC_W), .HV_W(HV_W), .IVEC_W(IVEC_W)
) u_chk (.*);

// File: tb/tb_prst_ctrl.sv
module tb_prst_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw = 0, sw = 0, st = 0, wen = 0;
  logic [3:0]  wsel = '0;
  logic [15:0] wd = '0;

  logic [15:0] bus_ctl_o;
  logic        pb_ctl_o;
  logic [14:0] pb_dir_o, pb_dat_o;
  logic [8:0]  pc_ctl_o, pc_dir_o, pc_dat_o;
  logic [4:0]  host_ctl_o, host_ictl_o;
  logic [5:0]  host_sts_o, host_cmd_o;
  logic [3:0]  host_isr_o;
  logic [7:0]  host_ivec_o;
  logic        host_irst_o, sci_irst_o, ssi_irst_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prst_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .hw_rst_i(hw), .sw_rst_i(sw), .stop_rst_i(st),
    .wr_en_i(wen), .wr_sel_i(wsel), .wr_data_i(wd),
    .bus_ctl_o, .pb_ctl_o, .pb_dir_o, .pb_dat_o, .pc_ctl_o, .pc_dir_o, .pc_dat_o,
    .host_ctl_o, .host_sts_o, .host_ictl_o, .host_cmd_o, .host_isr_o, .host_ivec_o,
    .host_irst_o, .sci_irst_o, .ssi_irst_o
  );

  // reference model state
  logic [15:0] m_bus;
  logic        m_pbc;
  logic [14:0] m_pbd, m_pbdat;
  logic [8:0]  m_pcc, m_pcd, m_pcdat;
  logic [4:0]  m_hctl, m_hictl;
  logic [5:0]  m_hsts, m_hcmd;
  logic [3:0]  m_hisr;
  logic [7:0]  m_hivec;

  function automatic bit w(int k);
    return wen && (int'(wsel) == k);
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit hind, hs, anyh;
    if (!rst_n) begin
      m_bus = 16'hFFFF; m_pbc = 0; m_pbd = 0; m_pbdat = 0;
      m_pcc = 0; m_pcd = 0; m_pcdat = 0;
      m_hctl = 0; m_hsts = 6'b000010; m_hictl = 0; m_hcmd = 6'h12;
      m_hisr = 4'b0110; m_hivec = 8'h0F;
    end else begin
      hind = (m_pbc == 1'b0);
      hs   = hw || sw;
      anyh = hs || st || hind;
      if (hw) m_bus = 16'hFFFF; else if (w(0)) m_bus = wd;
      if (hs) m_pbc = 0; else if (w(1)) m_pbc = wd[0];
      if (hs) m_pbd = 0; else if (w(2)) m_pbd = wd[14:0];
      if (w(3)) m_pbdat = wd[14:0];
      if (hs) m_pcc = 0; else if (w(4)) m_pcc = wd[8:0];
      if (hs) m_pcd = 0; else if (w(5)) m_pcd = wd[8:0];
      if (w(6)) m_pcdat = wd[8:0];
      if (hs) m_hctl = 0; else if (w(7)) m_hctl = wd[4:0];
      if (anyh) m_hsts = 6'b000010; else if (w(8)) m_hsts = wd[5:0];
      if (anyh) m_hictl = 0; else if (w(9)) m_hictl = wd[4:0];
      if (anyh) m_hcmd = 6'h12; else if (w(10)) m_hcmd = wd[5:0];
      if (anyh) m_hisr = 4'b0110; else if (w(11)) m_hisr = wd[3:0];
      if (hs) m_hivec = 8'h0F; else if (w(12)) m_hivec = wd[7:0];
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("R3",  "bus_ctl",   32'(bus_ctl_o),   32'(m_bus));
    chk("R4",  "pb_ctl",    32'(pb_ctl_o),    32'(m_pbc));
    chk("R4",  "pb_dir",    32'(pb_dir_o),    32'(m_pbd));
    chk("R5",  "pb_dat",    32'(pb_dat_o),    32'(m_pbdat));
    chk("R4",  "pc_ctl",    32'(pc_ctl_o),    32'(m_pcc));
    chk("R4",  "pc_dir",    32'(pc_dir_o),    32'(m_pcd));
    chk("R5",  "pc_dat",    32'(pc_dat_o),    32'(m_pcdat));
    chk("R6",  "host_ctl",  32'(host_ctl_o),  32'(m_hctl));
    chk("R7",  "host_sts",  32'(host_sts_o),  32'(m_hsts));
    chk("R8",  "host_ictl", 32'(host_ictl_o), 32'(m_hictl));
    chk("R8",  "host_cmd",  32'(host_cmd_o),  32'(m_hcmd));
    chk("R8",  "host_isr",  32'(host_isr_o),  32'(m_hisr));
    chk("R9",  "host_ivec", 32'(host_ivec_o), 32'(m_hivec));
    chk("R2",  "host_irst", 32'(host_irst_o), 32'(m_pbc == 1'b0));
    chk("R2",  "sci_irst",  32'(sci_irst_o),  32'(m_pcc[2:0] == 3'd0));
    chk("R2",  "ssi_irst",  32'(ssi_irst_o),  32'(m_pcc[8:3] == 6'd0));
  end

  // drive one cycle of stimulus, release it, return at the next falling edge
  task automatic step(bit h, bit s, bit p, bit we, int sel, logic [15:0] d);
    @(negedge clk); #1;
    hw = h; sw = s; st = p; wen = we; wsel = 4'(sel); wd = d;
    @(posedge clk); #1;
    hw = 0; sw = 0; st = 0; wen = 0;
    @(negedge clk);
  endtask

  task automatic wr(int sel, logic [15:0] d);
    step(0, 0, 0, 1, sel, d);
  endtask

  task automatic load_all();
    wr(1, 16'h0001);
    wr(4, 16'h01FF);
    wr(0, 16'h1234); wr(2, 16'h2AAA); wr(3, 16'h1555);
    wr(5, 16'h0155); wr(6, 16'h00AA);
    wr(7, 16'h001F); wr(8, 16'h003D); wr(9, 16'h001B);
    wr(10, 16'h002C); wr(11, 16'h0009); wr(12, 16'h00A5);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", "bus_ctl rst",   32'(bus_ctl_o),   32'hFFFF);
    chk("R1", "pb_dir rst",    32'(pb_dir_o),    32'h0);
    chk("R1", "host_sts rst",  32'(host_sts_o),  32'h02);
    chk("R1", "host_cmd rst",  32'(host_cmd_o),  32'h12);
    chk("R1", "host_isr rst",  32'(host_isr_o),  32'h6);
    chk("R1", "host_ivec rst", 32'(host_ivec_o), 32'h0F);
    chk("R1", "irst rst",      32'({host_irst_o, sci_irst_o, ssi_irst_o}), 32'h7);
    #1 rst_n = 1;

    load_all();
    chk("R10", "bus write",   32'(bus_ctl_o),  32'h1234);
    chk("R2",  "host released", 32'(host_irst_o), 32'h0);
    chk("R10", "sts write",   32'(host_sts_o), 32'h3D);
    wr(13, 16'hFFFF);
    chk("R10", "code 13 no effect", 32'(bus_ctl_o), 32'h1234);

    // software reset with a bus write in the same cycle: write survives
    step(0, 1, 0, 1, 0, 16'h5555);
    chk("R10", "bus write beside sw", 32'(bus_ctl_o), 32'h5555);
    chk("R4",  "pb_dir cleared by sw", 32'(pb_dir_o), 32'h0);
    chk("R9",  "ivec on sw",  32'(host_ivec_o), 32'h0F);
    chk("R6",  "hctl on sw",  32'(host_ctl_o),  32'h0);

    load_all();
    // stop reset with a status write: write dropped
    step(0, 0, 1, 1, 8, 16'h003F);
    chk("R10", "sts write dropped on stop", 32'(host_sts_o), 32'h02);
    chk("R4",  "pb_dir held on stop", 32'(pb_dir_o), 32'h2AAA);
    chk("R6",  "hctl held on stop",   32'(host_ctl_o), 32'h1F);
    chk("R9",  "ivec held on stop",   32'(host_ivec_o), 32'hA5);
    chk("R3",  "bus held on stop",    32'(bus_ctl_o), 32'h1234);

    load_all();
    // R11 software and stop together
    step(0, 1, 1, 0, 0, 16'h0);
    chk("R11", "sw+stop clears pc_dir", 32'(pc_dir_o), 32'h0);
    chk("R11", "sw+stop bus held",      32'(bus_ctl_o), 32'h1234);

    load_all();
    // all three strobes plus data write
    step(1, 1, 1, 1, 3, 16'h0F0F);
    chk("R11", "all strobes bus", 32'(bus_ctl_o), 32'hFFFF);
    chk("R5",  "data write through strobes", 32'(pb_dat_o), 32'h0F0F);
    chk("R5",  "pc_dat untouched", 32'(pc_dat_o), 32'h0AA);

    load_all();
    wr(4, 16'h0007);
    chk("R2", "ssi irst", 32'(ssi_irst_o), 32'h1);
    chk("R2", "sci running", 32'(sci_irst_o), 32'h0);
    wr(1, 16'h0000);
    chk("R2", "host irst", 32'(host_irst_o), 32'h1);
    step(0, 0, 0, 0, 0, 16'h0);
    chk("R7", "sts in host indiv",   32'(host_sts_o), 32'h02);
    chk("R8", "cmd in host indiv",   32'(host_cmd_o), 32'h12);
    chk("R6", "hctl held in indiv",  32'(host_ctl_o), 32'h1F);
    chk("R9", "ivec held in indiv",  32'(host_ivec_o), 32'hA5);
    wr(8, 16'h0015);
    chk("R10", "sts write dropped in indiv", 32'(host_sts_o), 32'h02);
    wr(7, 16'h0003);
    chk("R10", "hctl write in indiv", 32'(host_ctl_o), 32'h03);

    // random overlap phase
    for (int i = 0; i < 500; i++) begin
      logic [31:0] r;
      r = $urandom;
      @(negedge clk); #1;
      hw   = (r[4:0] == 5'd0);
      sw   = (r[9:5] == 5'd1);
      st   = (r[13:10] == 4'd2);
      wen  = r[14];
      wsel = r[18:15];
      wd   = r[31:16];
    end
    @(negedge clk); #1;
    hw = 0; sw = 0; st = 0; wen = 0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule